// File: doc/BRIEF.md
# Counted Value Repeater

This block takes in requests, each made of a data word and an unsigned repeat count. For each request it sends the data word out that many times. It is used as a broadcast helper: one operand fetched once is turned into a stream of identical copies, which downstream logic hands to several processing elements.

Both edges use a valid/ready handshake, and each edge is backed by a small queue:

- A request is taken in a cycle where `req_valid` and `req_ready` are both high.
- A copy is delivered in a cycle where `out_valid` and `out_ready` are both high.

Between the two queues sits a sequencer. It takes one request at a time and moves a copy forward only when the output queue has a free slot. Because of this, either side may stall for any number of cycles without losing or duplicating a copy.

A request with a count of zero is removed from the input queue and produces nothing. The sequencer does not take the next request until the burst in progress has been fully handed to the output queue.

Top module: `data_repeater`

## Requirements
- R1: After reset, `out_valid` is low and `req_ready` is high.
- R2: A request with value V and count N (N greater than zero) produces exactly N output transfers, each carrying V. For example, value 15 with count 3 gives three outputs of 15.
- R3: A request with count zero is consumed and produces no output transfer. The request after it is served normally.
- R4: Copies of successive requests leave in request order. The copies of one request are never interleaved with those of another.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value on the next cycle.
- R6: Under any pattern of output stalls, the remaining count of a burst holds while the output queue is full. No copy is lost or repeated.
- R7: A new request is not taken from the input queue while a burst is in progress. With the default input queue depth of 2 and the output stalled, after three requests have been accepted (the first one being served), `req_ready` is low.
- R8: The count is an unsigned `CNT_W`-bit field (default 8). Count 1 gives a single copy, and the maximum count of 255 gives 255 copies. The data word is `DATA_W` bits (default 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Input queue can take a request |
| req_data | input | DATA_W | Value to repeat |
| req_count | input | CNT_W | Number of copies wanted |
| out_valid | output | 1 | A copy is available |
| out_ready | input | 1 | Consumer takes the copy this cycle |
| out_data | output | DATA_W | Copy being offered |

## Verification
The bench targets four corner cases:

- **Zero count.** A design that got this wrong would emit a stray copy, or would stall the request that follows.
- **Counts 1 and 255.** Off-by-one counting would show up here as a missing or extra copy.
- **Random output stalls during long bursts.** A counter that decrements without a successful push would drop copies under these stalls.
- **A fully stalled burst with further requests queued behind it.** An eager sequencer would take a request early and interleave bursts. Unstable output data would show up as a changed word during the stall.

// File: rtl/rep_pkg.sv
// Package: shared types for the counted value repeater.
// Assumes nothing beyond standard SystemVerilog.
package rep_pkg;

    // Sequencer phase: waiting for a request, or emitting a burst.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rep_fifo.sv
// Module: rep_fifo
// Small synchronous queue with a registered occupancy count.
// A push is honoured only when the queue is not full, and a pop only when it is
// not empty; a push and a pop may happen in the same cycle.
// The head entry is presented combinationally from the storage array.
// Assumes DEPTH >= 1.
module rep_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    assign full      = (cnt == CW'(DEPTH));
    assign empty     = (cnt == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = mem[rd_ptr];

    // Advance a pointer with wrap at the last slot.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the storage slot on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // Occupancy never exceeds the number of slots.
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // A full queue asked only to push keeps its occupancy.
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/rep_sequencer.sv
// Module: rep_sequencer
// Takes one request at a time from the input queue and pushes copies of its
// value into the output queue, counting down the remaining copies.
// Assumes in_avail/in_data/in_count reflect the input queue head and
// out_space means the output queue has a free slot this cycle.
module rep_sequencer
    import rep_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_avail,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_count,
    output logic              in_take,
    input  logic              out_space,
    output logic              out_put,
    output logic [DATA_W-1:0] out_val,
    output logic              busy
);

    seq_state_e        state;
    logic [CNT_W-1:0]  remaining;
    logic [DATA_W-1:0] held;

    assign busy    = (state == SEQ_BURST);
    assign in_take = (state == SEQ_IDLE) && in_avail;
    assign out_put = busy && out_space;
    assign out_val = held;

    // Load a request, then count copies down until the burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            remaining <= '0;
            held      <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (in_avail && (in_count != '0)) begin
                        held      <= in_data;
                        remaining <= in_count;
                        state     <= SEQ_BURST;
                    end
                end
                SEQ_BURST: begin
                    if (out_space) begin
                        remaining <= remaining - 1'b1;
                        if (remaining == CNT_W'(1)) begin
                            state <= SEQ_IDLE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Stalled output: the remaining count holds.
    assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_space) |=> (busy && remaining == $past(remaining)));

    // A burst in progress always has copies left to emit.
    assert_burst_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remaining != '0));

    // A non-zero request starts a burst with its full count.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take && in_count != '0) |=> (busy && remaining == $past(in_count)));

    // A zero-count request leaves the sequencer idle.
    assert_zero_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take && in_count == '0) |=> !busy);

endmodule

// File: rtl/data_repeater.sv
// Module: data_repeater (top)
// Counted value repeater. Requests {value, count} enter an input queue; a
// sequencer expands each into count copies pushed into an output queue.
// Assumes a single clock and synchronous active-low reset.
module data_repeater #(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int IN_DEPTH  = 2,
    parameter int OUT_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CNT_W-1:0]  req_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int REQ_W = DATA_W + CNT_W;

    logic [REQ_W-1:0]  req_head;
    logic              req_full;
    logic              req_empty;
    logic              seq_take;
    logic              seq_put;
    logic [DATA_W-1:0] seq_val;
    logic              seq_busy;
    logic              out_full;
    logic              out_empty;

    assign req_ready = !req_full;
    assign out_valid = !out_empty;

    rep_fifo #(.WIDTH(REQ_W), .DEPTH(IN_DEPTH)) u_req_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid),
        .push_data ({req_data, req_count}),
        .pop       (seq_take),
        .head_data (req_head),
        .full      (req_full),
        .empty     (req_empty)
    );

    rep_sequencer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_avail  (!req_empty),
        .in_data   (req_head[REQ_W-1:CNT_W]),
        .in_count  (req_head[CNT_W-1:0]),
        .in_take   (seq_take),
        .out_space (!out_full),
        .out_put   (seq_put),
        .out_val   (seq_val),
        .busy      (seq_busy)
    );

    rep_fifo #(.WIDTH(DATA_W), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (seq_put),
        .push_data (seq_val),
        .pop       (out_ready),
        .head_data (out_data),
        .full      (out_full),
        .empty     (out_empty)
    );

    // A stalled copy stays offered and unchanged.
    assert_out_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // While a burst runs, the input queue is not drained.
    assert_no_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !req_empty && !req_valid) |=> !req_empty);

endmodule

// File: tb/data_repeater_tb.sv
module data_repeater_tb;

    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_data = '0;
    logic [CW-1:0] req_count = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int bp_mode = 0;   // 0 always ready, 1 random, 2 held low

    logic [DW-1:0] exp_d[$];
    string         exp_t[$];

    always #5 clk = ~clk;

    data_repeater #(.DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_count(req_count),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: offer one request and record its expected copies.
    task automatic send(input logic [DW-1:0] d, input logic [CW-1:0] n, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_data  = d;
        req_count = n;
        while (!req_ready) @(negedge clk);
        for (int i = 0; i < int'(n); i++) begin
            exp_d.push_back(d);
            exp_t.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Back-pressure generator, changing away from the sampling edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            case (bp_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = 1'($urandom_range(0, 1));
                default: out_ready = 1'b0;
            endcase
        end
    end

    // Monitor: compare each transfer with the scoreboard and watch stalls.
    initial begin
        bit            stalled = 1'b0;
        logic [DW-1:0] stall_d = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (stalled) begin
                    check(out_valid == 1'b1, "R5", "valid during stall", out_valid, 1);
                    check(out_data == stall_d, "R5", "data during stall", out_data, stall_d);
                end
                stalled = out_valid && !out_ready;
                stall_d = out_data;
                if (out_valid && out_ready) begin
                    if (exp_d.size() == 0) begin
                        check(1'b0, "R3", "unexpected output", out_data, 0);
                    end else begin
                        logic [DW-1:0] e;
                        string         t;
                        e = exp_d.pop_front();
                        t = exp_t.pop_front();
                        check(out_data == e, t, "copy value", out_data, e);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

        // Basic bursts with a free-running consumer.
        bp_mode = 0;
        send(16'd15, 8'd3, "R2");
        send(16'hA5A5, 8'd1, "R8");
        send(16'h00C3, 8'd4, "R4");

        // Zero count is dropped; the next request still runs.
        send(16'h1234, 8'd0, "R3");
        send(16'h0042, 8'd2, "R3");

        // Random stalls, including the maximum count.
        bp_mode = 1;
        send(16'h7001, 8'd7, "R6");
        send(16'h7002, 8'd1, "R6");
        send(16'hBEEF, 8'd255, "R8");
        send(16'h7003, 8'd0, "R3");
        send(16'h7004, 8'd5, "R4");
        while (exp_d.size() != 0) @(negedge clk);

        // Fully stalled burst with requests queued behind it.
        bp_mode = 2;
        repeat (3) @(negedge clk);
        send(16'hAAAA, 8'd4, "R7");
        repeat (5) @(negedge clk);
        send(16'hBBBB, 8'd2, "R4");
        send(16'hCCCC, 8'd3, "R4");
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, "R7", "req_ready with queue full", req_ready, 0);
        check(out_valid == 1'b1, "R5", "copy offered while stalled", out_valid, 1);
        check(out_data == 16'hAAAA, "R5", "head copy while stalled", out_data, 16'hAAAA);
        bp_mode = 1;
        while (exp_d.size() != 0) @(negedge clk);

        // Drain and confirm nothing further appears.
        bp_mode = 0;
        repeat (20) @(negedge clk);
        check(exp_d.size() == 0, "R2", "copies outstanding", exp_d.size(), 0);
        check(out_valid == 1'b0, "R4", "idle after all bursts", out_valid, 0);
        check(req_ready == 1'b1, "R7", "ready after all bursts", req_ready, 1);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule